// File: doc/BRIEF.md
# Upstream Stream-to-Buffer DMA Controller

This block sits between user logic on the FPGA side and a host-memory write path. User logic pushes words through a valid/ready stream. The block packs those words, one after another, into a ring of equal-sized host buffers. Each stored word leaves as a memory-write request that carries a full address and the data word. Once a buffer has been filled, the block hands it to the host with a release message. The message names the buffer and states how many bytes it holds. After that the block moves on to the next buffer in the ring.

The host can also order a flush. A flush hands over the current buffer even when only part of it is filled, and the byte count in the message tells the host how much of it is valid. A buffer that has been handed over belongs to the host. The block will not write to it again until the host returns it with a return strobe that carries the buffer's index. If the buffer the block would write next is still held by the host, the block drops ready, so no data is ever lost. An optional notification pulse marks the moment the channel goes from holding nothing to holding data. The bus protocol, interrupts and message transport sit outside the block, behind these plain request ports.

Top module: `stream_buf_dma`

## Requirements
- R1: After reset, inReady is 1 and wrValid, relValid and neValid are 0. The block writes into buffer 0 starting at byte offset 0.
- R2: For each cycle with inValid and inReady both high, wrValid is high in the next cycle. In that cycle wrData equals the accepted word, and wrAddr equals BASE_ADDR + index*BUF_BYTES + offset.
- R3: The byte offset grows by WORD_BITS/8 with each accepted word. Take the cycle in which a word brings the offset up to BUF_BYTES. In the next cycle relValid is high, relIdx is the buffer index and relBytes is BUF_BYTES. The following word goes to the next buffer at offset 0.
- R4: A flushReq pulse while the current buffer holds data releases that buffer in the next cycle. relBytes is the number of bytes held, and it includes a word accepted in the same cycle as the flush. Writing then continues in the next buffer at offset 0.
- R5: A flushReq pulse while the current buffer holds no data and no word is being accepted produces no release message and leaves the buffer index unchanged.
- R6: A released buffer is owned by the host. While the current buffer is host-owned, inReady is 0 and no write request is issued.
- R7: A retValid pulse with retIdx clears host ownership of that buffer. A return for a buffer that the host does not own has no effect.
- R8: If neEnable is 1, accepting a word while the current buffer is empty makes neValid a one-cycle pulse in the next cycle. If neEnable is 0, neValid stays 0.
- R9: The buffer index wraps from NUM_BUFS-1 back to 0.
- R10: WORD_BITS selects 8-, 16- or 32-bit stream words. NUM_BUFS and BUF_BYTES are powers of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Stream word offered by user logic |
| inData | input | WORD_BITS | Stream word |
| inReady | output | 1 | Block can take a word this cycle |
| flushReq | input | 1 | Host command: hand over the partial buffer |
| retValid | input | 1 | Host returns a buffer |
| retIdx | input | log2(NUM_BUFS) | Index of the returned buffer |
| neEnable | input | 1 | Enables the empty-to-data notification |
| wrValid | output | 1 | Memory-write request valid |
| wrAddr | output | ADDR_W | Write byte address |
| wrData | output | WORD_BITS | Write data word |
| relValid | output | 1 | Release message valid |
| relIdx | output | log2(NUM_BUFS) | Released buffer index |
| relBytes | output | log2(BUF_BYTES)+1 | Valid bytes in released buffer |
| neValid | output | 1 | Channel went from empty to holding data |

## Verification
The bench drives a flush in the same cycle as the word that completes a buffer. A design that got this wrong would emit two release messages, or one with the wrong count. It also drives a flush together with a single word into an empty buffer, where the count must include that word, and a flush on an empty buffer, which must stay silent. It fills every buffer until ready drops and keeps offering data; a design with a broken ownership check would overwrite a host-held buffer. It returns a buffer the host never held and the wrong buffer, either of which a careless mask update would turn into a spurious ready. A long random phase with random returns and flushes checks index wrap and the notification rule against a behavioural model on every cycle.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  // Per-cycle decisions passed from control to datapath
  typedef struct packed {
    logic take;   // a stream word is accepted
    logic hand;   // the current buffer is handed to the host
    logic note;   // empty-to-data notification
  } sbdStrobe_t;
endpackage

// File: rtl/sbd_ctrl.sv
module sbd_ctrl
  import sbd_pkg::*;
#(
  parameter int NUM_BUFS  = 4,
  parameter int BUF_BYTES = 16,
  parameter int WORD_BITS = 32,
  localparam int IDX_W = $clog2(NUM_BUFS),
  localparam int OFF_W = $clog2(BUF_BYTES),
  localparam int CNT_W = OFF_W + 1,
  localparam int BPW   = WORD_BITS / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             flushReq,
  input  logic             retValid,
  input  logic [IDX_W-1:0] retIdx,
  input  logic             neEnable,
  output logic             inReady,
  output sbdStrobe_t       strobe,
  output logic [IDX_W-1:0] curIdx,
  output logic [OFF_W-1:0] curFill,
  output logic [CNT_W-1:0] sumBytes
);
  logic [NUM_BUFS-1:0] hostOwned, ownedNext;

  assign inReady = !hostOwned[curIdx];

  always_comb begin
    strobe.take = inValid && inReady;
    sumBytes    = CNT_W'(curFill) + (strobe.take ? CNT_W'(BPW) : '0);
    strobe.hand = (strobe.take && (sumBytes == CNT_W'(BUF_BYTES)))
               || (flushReq && (sumBytes != '0));
    strobe.note = strobe.take && (curFill == '0) && neEnable;
    ownedNext = hostOwned;
    if (retValid) ownedNext[retIdx] = 1'b0;
    if (strobe.hand) ownedNext[curIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostOwned <= '0;
      curIdx    <= '0;
      curFill   <= '0;
    end else begin
      hostOwned <= ownedNext;
      if (strobe.hand) begin
        curIdx  <= curIdx + IDX_W'(1);
        curFill <= '0;
      end else if (strobe.take) begin
        curFill <= sumBytes[OFF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sbd_path.sv
module sbd_path
  import sbd_pkg::*;
#(
  parameter int NUM_BUFS  = 4,
  parameter int BUF_BYTES = 16,
  parameter int WORD_BITS = 32,
  parameter int ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000_0000,
  localparam int IDX_W = $clog2(NUM_BUFS),
  localparam int OFF_W = $clog2(BUF_BYTES),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sbdStrobe_t           strobe,
  input  logic [IDX_W-1:0]     curIdx,
  input  logic [OFF_W-1:0]     curFill,
  input  logic [CNT_W-1:0]     sumBytes,
  input  logic [WORD_BITS-1:0] inData,
  output logic                 wrValid,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [WORD_BITS-1:0] wrData,
  output logic                 relValid,
  output logic [IDX_W-1:0]     relIdx,
  output logic [CNT_W-1:0]     relBytes,
  output logic                 neValid
);
  logic [ADDR_W-1:0] byteAddr;
  assign byteAddr = BASE_ADDR + (ADDR_W'(curIdx) << OFF_W) + ADDR_W'(curFill);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid  <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      relValid <= 1'b0;
      relIdx   <= '0;
      relBytes <= '0;
      neValid  <= 1'b0;
    end else begin
      wrValid  <= strobe.take;
      relValid <= strobe.hand;
      neValid  <= strobe.note;
      if (strobe.take) begin
        wrAddr <= byteAddr;
        wrData <= inData;
      end
      if (strobe.hand) begin
        relIdx   <= curIdx;
        relBytes <= sumBytes;
      end
    end
  end
endmodule

// File: rtl/stream_buf_dma.sv
module stream_buf_dma
  import sbd_pkg::*;
#(
  parameter int NUM_BUFS  = 4,
  parameter int BUF_BYTES = 16,
  parameter int WORD_BITS = 32,
  parameter int ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000_0000,
  localparam int IDX_W = $clog2(NUM_BUFS),
  localparam int OFF_W = $clog2(BUF_BYTES),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [WORD_BITS-1:0] inData,
  output logic                 inReady,
  input  logic                 flushReq,
  input  logic                 retValid,
  input  logic [IDX_W-1:0]     retIdx,
  input  logic                 neEnable,
  output logic                 wrValid,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [WORD_BITS-1:0] wrData,
  output logic                 relValid,
  output logic [IDX_W-1:0]     relIdx,
  output logic [CNT_W-1:0]     relBytes,
  output logic                 neValid
);
  sbdStrobe_t       strobe;
  logic [IDX_W-1:0] curIdx;
  logic [OFF_W-1:0] fillLevel;
  logic [CNT_W-1:0] sumBytes;

  sbd_ctrl #(.NUM_BUFS(NUM_BUFS), .BUF_BYTES(BUF_BYTES), .WORD_BITS(WORD_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .flushReq(flushReq),
    .retValid(retValid), .retIdx(retIdx), .neEnable(neEnable), .inReady(inReady),
    .strobe(strobe), .curIdx(curIdx), .curFill(fillLevel), .sumBytes(sumBytes)
  );

  sbd_path #(.NUM_BUFS(NUM_BUFS), .BUF_BYTES(BUF_BYTES), .WORD_BITS(WORD_BITS),
             .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curIdx(curIdx), .curFill(fillLevel),
    .sumBytes(sumBytes), .inData(inData), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .relValid(relValid), .relIdx(relIdx), .relBytes(relBytes),
    .neValid(neValid)
  );
endmodule

// File: rtl/sbd_chk.sv
module sbd_chk #(
  parameter int WORD_BITS = 32,
  parameter int NUM_BUFS  = 4,
  parameter int BUF_BYTES = 16,
  localparam int OFF_W = $clog2(BUF_BYTES),
  localparam int CNT_W = OFF_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             flushReq,
  input logic             neEnable,
  input logic             wrValid,
  input logic             relValid,
  input logic [CNT_W-1:0] relBytes,
  input logic             neValid,
  input logic [OFF_W-1:0] fillLevel
);
  // R10
  initial begin
    word_format_chk: assert (WORD_BITS == 8 || WORD_BITS == 16 || WORD_BITS == 32);
    pow2_chk: assert (NUM_BUFS >= 2 && (NUM_BUFS & (NUM_BUFS - 1)) == 0
                      && (BUF_BYTES & (BUF_BYTES - 1)) == 0 && BUF_BYTES >= WORD_BITS / 8);
  end

  // R2
  accept_writes_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> wrValid);

  // R6
  blocked_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !wrValid);

  // R3
  rel_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> (relBytes != '0) && (relBytes <= CNT_W'(BUF_BYTES)));

  // R5
  empty_flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq && !(inValid && inReady) && (fillLevel == '0) |=> !relValid);

  // R8
  ne_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    neValid |-> $past(neEnable));
endmodule

bind stream_buf_dma sbd_chk #(.WORD_BITS(WORD_BITS), .NUM_BUFS(NUM_BUFS), .BUF_BYTES(BUF_BYTES)) u_sbd_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .flushReq(flushReq),
  .neEnable(neEnable), .wrValid(wrValid), .relValid(relValid), .relBytes(relBytes),
  .neValid(neValid), .fillLevel(fillLevel)
);

// File: tb/test_stream_buf_dma.sv
`timescale 1ns/1ps
module test_stream_buf_dma;
  localparam int NB = 4, BB = 16, WB = 32, AW = 32;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam int BPW = WB / 8;
  localparam int IW = $clog2(NB), CW = $clog2(BB) + 1;

  logic clk = 0, rstN = 0;
  logic inValid = 0, flushReq = 0, retValid = 0, neEnable = 1;
  logic [WB-1:0] inData = '0;
  logic [IW-1:0] retIdx = '0;
  logic inReady, wrValid, relValid, neValid;
  logic [AW-1:0] wrAddr;
  logic [WB-1:0] wrData;
  logic [IW-1:0] relIdx;
  logic [CW-1:0] relBytes;

  int nChecks = 0, nFails = 0;
  bit checking = 0, done = 0;

  always #2 clk = ~clk;

  stream_buf_dma #(.NUM_BUFS(NB), .BUF_BYTES(BB), .WORD_BITS(WB), .ADDR_W(AW),
                   .BASE_ADDR(BASE)) i_stream_buf_dma (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .flushReq(flushReq), .retValid(retValid), .retIdx(retIdx), .neEnable(neEnable),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .relValid(relValid),
    .relIdx(relIdx), .relBytes(relBytes), .neValid(neValid)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit mOwned[NB];
  int mCur, mFill;
  bit eWr, eRel, eNe;
  longint eAddr, eData, eRelIdx, eRelBytes;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mOwned[i]) mOwned[i] = 0;
      mCur = 0; mFill = 0; eWr = 0; eRel = 0; eNe = 0;
    end else begin
      bit acc;
      int sum;
      acc = inValid && !mOwned[mCur];
      sum = mFill + (acc ? BPW : 0);
      eWr = acc;
      if (acc) begin
        eAddr = BASE + mCur * BB + mFill;
        eData = inData;
      end
      eRel = (acc && sum == BB) || (flushReq && sum != 0);
      if (eRel) begin
        eRelIdx = mCur;
        eRelBytes = sum;
      end
      eNe = acc && mFill == 0 && neEnable;
      if (retValid) mOwned[retIdx] = 0;
      if (eRel) begin
        mOwned[mCur] = 1;
        mCur = (mCur + 1) % NB;
        mFill = 0;
      end else if (acc) mFill = sum;
    end
  end

  always @(negedge clk) if (checking) begin
    chk(inReady == !mOwned[mCur], "R6 inReady", inReady, !mOwned[mCur]);
    chk(wrValid == eWr, "R2 wrValid", wrValid, eWr);
    if (eWr) begin
      chk(wrAddr == eAddr, "R2 wrAddr", wrAddr, eAddr);
      chk(wrData == eData, "R2 wrData", wrData, eData);
    end
    chk(relValid == eRel, "R3/R4 relValid", relValid, eRel);
    if (eRel) begin
      chk(relIdx == eRelIdx, "R9 relIdx", relIdx, eRelIdx);
      chk(relBytes == eRelBytes, "R4 relBytes", relBytes, eRelBytes);
    end
    chk(neValid == eNe, "R8 neValid", neValid, eNe);
  end

  task automatic cyc(input bit v, input logic [WB-1:0] d, input bit f,
                     input bit r, input int ri);
    @(negedge clk);
    inValid = v; inData = d; flushReq = f; retValid = r; retIdx = IW'(ri);
  endtask

  task automatic idle(); cyc(0, '0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(inReady == 1, "R1 inReady", inReady, 1);
    chk(!wrValid && !relValid && !neValid, "R1 valids", {wrValid, relValid, neValid}, 0);
    rstN = 1;
    checking = 1;
    // R2 R3 full buffer 0, then R8 notify
    for (int i = 0; i < 4; i++) cyc(1, 32'hA000 + i, 0, 0, 0);
    idle(); idle();
    // R4 partial flush of buffer 1
    cyc(1, 32'hB1, 0, 0, 0); cyc(1, 32'hB2, 0, 0, 0); cyc(0, 0, 1, 0, 0); idle();
    // R5 flush while empty
    cyc(0, 0, 1, 0, 0); idle(); idle();
    chk(!relValid, "R5 no release", relValid, 0);
    // R4 flush with word in same cycle
    cyc(1, 32'hC1, 0, 0, 0); cyc(1, 32'hC2, 1, 0, 0); idle();
    // R8 disabled notification, fill buffer 3
    neEnable = 0;
    for (int i = 0; i < 4; i++) cyc(1, 32'hD0 + i, 0, 0, 0);
    idle();
    // R6 all owned: push anyway
    for (int i = 0; i < 3; i++) cyc(1, 32'hEE, 0, 0, 0);
    @(negedge clk);
    chk(inReady == 0, "R6 all owned", inReady, 0);
    chk(!wrValid, "R6 no write", wrValid, 0);
    // R7 return wrong buffer: still blocked
    cyc(0, 0, 0, 1, 2); idle();
    @(negedge clk);
    chk(inReady == 0, "R7 wrong return", inReady, 0);
    // R7 return buffer 0, then R9 wrap write
    neEnable = 1;
    cyc(0, 0, 0, 1, 0); idle();
    @(negedge clk);
    chk(inReady == 1, "R7 returned", inReady, 1);
    cyc(1, 32'hF0, 0, 0, 0); idle();
    // R7 return of a not-owned buffer (3 still owned, 0 now free)
    cyc(0, 0, 0, 1, 0); idle();
    for (int i = 1; i < NB; i++) cyc(0, 0, 0, 1, i);
    // Random phase
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 3) != 0, $urandom, $urandom_range(0, 15) == 0,
          $urandom_range(0, 3) == 0, $urandom_range(0, NB - 1));
    neEnable = 0;
    for (int i = 0; i < 500; i++)
      cyc($urandom_range(0, 1), $urandom, $urandom_range(0, 9) == 0,
          $urandom_range(0, 2) == 0, $urandom_range(0, NB - 1));
    idle(); idle();
    checking = 0;
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule